// File: doc/BRIEF.md
# Multiplier Operand Front End with Pre-Adder

This block prepares both operands of a signed multiplier. The first operand comes from a short A-input pipeline. A 4-bit operand code can pick either pipeline stage of A, or zero it. It can also negate it, or add it to a D input or subtract it from D, through a pre-adder. The second operand is one of two B pipeline stages. Both operands are held in output registers that share one clock enable and one synchronous reset.

Two parameters shape the block. The first says whether the D input is present. The second sets how many register stages A has (0, 1 or 2). When D is absent, only the plain A-stage and zero codes are accepted. Any code that is not accepted raises an error flag and zeroes the first operand.

Top module: `preadd_operand_sel`

## Requirements
- R1: With `rst` high at a rising clock edge, `mult_a`, `mult_b` and `mode_err` all become 0, and so do all internal pipeline stages.
- R2: With `ce` low and `rst` low, no register changes, so all outputs hold their values.
- R3: Mode bits [3:0] select the plain operand. 4'b0000 gives the late A stage, 4'b0001 gives the early A stage, and 4'b0010 gives zero.
- R4: When D is present, the D codes are legal. 4'b0100 gives D plus the late A stage, 4'b0101 gives D plus the early A stage, and 4'b0110 gives D alone.
- R5: When D is present, the negate codes are legal. 4'b1000 gives minus the late A stage and 4'b1001 gives minus the early A stage. 4'b1100 gives D minus the late stage and 4'b1101 gives D minus the early stage.
- R6: With `D_EN` = 0, only codes 0000, 0001 and 0010 are legal, and every other code is flagged.
- R7: With `D_EN` = 1, the ten codes of R3 to R5 are legal. Every other value of bits [3:0] (0011, 0111, 1010, 1011, 1110, 1111, and so on) is flagged.
- R8: For an illegal code, `mult_a` loads 0 and `mode_err` loads 1 on the same edge.
- R9: Mode bit 4 picks the second operand. A value of 0 selects the late B stage and a value of 1 selects the early B stage.
- R10: When `A_DEPTH` = 2, the early A stage lags `a_in` by one register and the late A stage lags it by two. When `A_DEPTH` = 0, both stages are `a_in` itself. The output register adds one more cycle in every case.
- R11: `mult_a` is signed and one bit wider than the wider of A and D, so no pre-adder result can overflow. For example, D = 32767 minus A = -32768 gives 65535.
- R12: The early B stage lags `b_in` by one register and the late B stage lags it by two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for every register |
| mode | input | 5 | [4] B select, [3:0] A operand code |
| a_in | input | A_W | Signed A input |
| d_in | input | D_W | Signed D input |
| b_in | input | B_W | B input |
| mult_a | output | P_W | Registered signed first operand |
| mult_b | output | B_W | Registered second operand |
| mode_err | output | 1 | Registered illegal-code flag |

## Verification
The checks assume that `mode` is sampled on the same edge as `d_in`. They also assume that the inputs are clean binary values once reset is released. Most of the stimulus holds each input for four cycles, so that both pipeline stages carry the same value and the result depends only on the code. Separate directed steps then change A or B exactly once and sample on the edge where the early and late stages disagree. A second instance with D removed and no A registers covers the narrower set of legal codes and the pass-through path.

// File: rtl/preadd_pkg.sv
package preadd_pkg;

    typedef struct packed {
        logic b_sel;
        logic neg_a;
        logic add_d;
        logic zero_a;
        logic pick_a1;
    } mode_t;

    function automatic int unsigned wider(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

    function automatic logic code_legal(input logic [3:0] c, input bit d_en);
        logic base;
        logic ext;
        base = (c == 4'b0000) || (c == 4'b0001) || (c == 4'b0010);
        ext  = (c == 4'b0100) || (c == 4'b0101) || (c == 4'b0110) ||
               (c == 4'b1000) || (c == 4'b1001) ||
               (c == 4'b1100) || (c == 4'b1101);
        return base || (d_en && ext);
    endfunction

endpackage

// File: rtl/preadd_a_pipe.sv
module preadd_a_pipe #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic signed [W-1:0] a_in,
    output logic signed [W-1:0] a_early,
    output logic signed [W-1:0] a_late
);
    generate
        if (DEPTH == 2) begin : g_two
            logic signed [W-1:0] s1, s2;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1 <= '0;
                    s2 <= '0;
                end else if (ce) begin
                    s1 <= a_in;
                    s2 <= s1;
                end
            end
            assign a_early = s1;
            assign a_late  = s2;
        end else if (DEPTH == 1) begin : g_one
            logic signed [W-1:0] s1;
            always_ff @(posedge clk) begin
                if (rst)     s1 <= '0;
                else if (ce) s1 <= a_in;
            end
            assign a_early = s1;
            assign a_late  = s1;
        end else begin : g_none
            assign a_early = a_in;
            assign a_late  = a_in;
        end
    endgenerate
endmodule

// File: rtl/preadd_b_pipe.sv
module preadd_b_pipe #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_early,
    output logic [W-1:0] b_late
);
    always_ff @(posedge clk) begin
        if (rst) begin
            b_early <= '0;
            b_late  <= '0;
        end else if (ce) begin
            b_early <= b_in;
            b_late  <= b_early;
        end
    end
endmodule

// File: rtl/preadd_core.sv
module preadd_core #(
    parameter int A_W  = 16,
    parameter int D_W  = 16,
    parameter int P_W  = 17,
    parameter bit D_EN = 1'b1
) (
    input  logic [3:0]            code,
    input  logic signed [A_W-1:0] a_early,
    input  logic signed [A_W-1:0] a_late,
    input  logic signed [D_W-1:0] d_in,
    output logic signed [P_W-1:0] sum,
    output logic                  legal
);
    import preadd_pkg::*;

    logic signed [P_W-1:0] a_ext, a_term, d_term;
    logic signed [A_W-1:0] a_pick;

    always_comb begin
        a_pick = code[0] ? a_early : a_late;
        a_ext  = code[1] ? '0 : {{(P_W-A_W){a_pick[A_W-1]}}, a_pick};
        a_term = code[3] ? -a_ext : a_ext;
        d_term = (D_EN && code[2]) ? {{(P_W-D_W){d_in[D_W-1]}}, d_in} : '0;
        sum    = d_term + a_term;
        legal  = code_legal(code, D_EN);
    end
endmodule

// File: rtl/preadd_operand_sel.sv
module preadd_operand_sel
    import preadd_pkg::*;
#(
    parameter int A_W     = 16,
    parameter int D_W     = 16,
    parameter int B_W     = 12,
    parameter int A_DEPTH = 2,
    parameter bit D_EN    = 1'b1,
    localparam int P_W    = wider(A_W, D_W) + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic [4:0]            mode,
    input  logic signed [A_W-1:0] a_in,
    input  logic signed [D_W-1:0] d_in,
    input  logic [B_W-1:0]        b_in,
    output logic signed [P_W-1:0] mult_a,
    output logic [B_W-1:0]        mult_b,
    output logic                  mode_err
);
    localparam bit DEPTH_OK = (A_DEPTH >= 0) && (A_DEPTH <= 2);

    mode_t                 m;
    logic signed [A_W-1:0] a_early, a_late;
    logic [B_W-1:0]        b_early, b_late;
    logic signed [P_W-1:0] sum;
    logic                  legal, ok;

    assign m  = mode_t'(mode);
    assign ok = legal && DEPTH_OK;

    preadd_a_pipe #(.W(A_W), .DEPTH(A_DEPTH)) u_apipe (
        .clk(clk), .rst(rst), .ce(ce), .a_in(a_in),
        .a_early(a_early), .a_late(a_late)
    );

    preadd_b_pipe #(.W(B_W)) u_bpipe (
        .clk(clk), .rst(rst), .ce(ce), .b_in(b_in),
        .b_early(b_early), .b_late(b_late)
    );

    preadd_core #(.A_W(A_W), .D_W(D_W), .P_W(P_W), .D_EN(D_EN)) u_core (
        .code(mode[3:0]), .a_early(a_early), .a_late(a_late), .d_in(d_in),
        .sum(sum), .legal(legal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_a   <= '0;
            mult_b   <= '0;
            mode_err <= 1'b0;
        end else if (ce) begin
            mult_a   <= ok ? sum : '0;
            mult_b   <= m.b_sel ? b_early : b_late;
            mode_err <= !ok;
        end
    end
endmodule

// File: rtl/preadd_operand_sel_chk.sv
module preadd_operand_sel_chk #(
    parameter int B_W  = 12,
    parameter int P_W  = 17,
    parameter bit D_EN = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ce,
    input logic [4:0]            mode,
    input logic [B_W-1:0]        b_early,
    input logic [B_W-1:0]        b_late,
    input logic signed [P_W-1:0] mult_a,
    input logic [B_W-1:0]        mult_b,
    input logic                  mode_err
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mult_a == '0 && mult_b == '0 && !mode_err));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(mult_a) && $stable(mult_b) && $stable(mode_err)));

    a_r3_zero_code: assert property (@(posedge clk) disable iff (rst)
        (ce && mode[3:0] == 4'b0010) |=> (mult_a == '0 && !mode_err));

    a_r6_no_d_flags: assert property (@(posedge clk) disable iff (rst)
        (!D_EN && ce && (mode[2] || mode[3])) |=> mode_err);

    a_r8_err_zero: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> (mult_a == '0));

    a_r9_b_select: assert property (@(posedge clk) disable iff (rst)
        ce |=> (mult_b == ($past(mode[4]) ? $past(b_early) : $past(b_late))));
endmodule

bind preadd_operand_sel preadd_operand_sel_chk #(.B_W(B_W), .P_W(P_W), .D_EN(D_EN)) u_chk (
    .clk(clk), .rst(rst), .ce(ce), .mode(mode),
    .b_early(b_early), .b_late(b_late),
    .mult_a(mult_a), .mult_b(mult_b), .mode_err(mode_err)
);

// File: tb/sim_preadd_operand_sel.sv
module sim_preadd_operand_sel;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b1;
    logic [4:0]         mode = '0;
    logic signed [15:0] a = '0;
    logic signed [15:0] d = '0;
    logic [11:0]        b = '0;

    logic signed [16:0] q0_a, q1_a;
    logic [11:0]        q0_b, q1_b;
    logic               q0_e, q1_e;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    preadd_operand_sel #(.A_W(16), .D_W(16), .B_W(12), .A_DEPTH(2), .D_EN(1'b1)) u0 (
        .clk(clk), .rst(rst), .ce(ce), .mode(mode), .a_in(a), .d_in(d), .b_in(b),
        .mult_a(q0_a), .mult_b(q0_b), .mode_err(q0_e)
    );

    preadd_operand_sel #(.A_W(16), .D_W(16), .B_W(12), .A_DEPTH(0), .D_EN(1'b0)) u1 (
        .clk(clk), .rst(rst), .ce(ce), .mode(mode), .a_in(a), .d_in(d), .b_in(b),
        .mult_a(q1_a), .mult_b(q1_b), .mode_err(q1_e)
    );

    typedef struct packed {
        logic [4:0] mode;
        int a;
        int d;
        int b;
        int ea;
        logic eerr;
        int req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{5'b00000,    100,  1000, 5,    100, 1'b0, 3},
        '{5'b00001,    100,  1000, 6,    100, 1'b0, 3},
        '{5'b00010,    100,  1000, 7,      0, 1'b0, 3},
        '{5'b00100,    100,  1000, 8,   1100, 1'b0, 4},
        '{5'b00101,    100,  1000, 9,   1100, 1'b0, 4},
        '{5'b00110,    100,  1000, 10,  1000, 1'b0, 4},
        '{5'b01000,    100,  1000, 11,  -100, 1'b0, 5},
        '{5'b01001,    100,  1000, 12,  -100, 1'b0, 5},
        '{5'b01100,    100,  1000, 13,   900, 1'b0, 5},
        '{5'b11101,    100,  1000, 14,   900, 1'b0, 5},
        '{5'b10011,    100,  1000, 15,     0, 1'b1, 7},
        '{5'b00111,    100,  1000, 16,     0, 1'b1, 7},
        '{5'b01010,    100,  1000, 17,     0, 1'b1, 7},
        '{5'b01111,    100,  1000, 18,     0, 1'b1, 7},
        '{5'b01100, -32768, 32767, 19, 65535, 1'b0, 11},
        '{5'b00100,  32767, 32767, 20, 65534, 1'b0, 11},
        '{5'b01000, -32768,     0, 21, 32768, 1'b0, 11},
        '{5'b00100, -32768, -32768, 22, -65536, 1'b0, 11}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [4:0] mo, input int av, input int dv, input int bv);
        mode = mo;
        a = 16'(av);
        d = 16'(dv);
        b = 12'(bv);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        drive(5'b00000, 55, 66, 77);
        repeat (3) @(negedge clk);
        check("R1 mult_a", int'(q0_a), 0);
        check("R1 mult_b", int'(q0_b), 0);
        check("R1 mode_err", int'(q0_e), 0);
        rst = 1'b0;

        // R3 R4 R5 R7 R9 R11: held-input vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].mode, VECS[i].a, VECS[i].d, VECS[i].b);
            repeat (4) @(negedge clk);
            check($sformatf("R%0d vec%0d mult_a", VECS[i].req, i), int'(q0_a), VECS[i].ea);
            check($sformatf("R8 vec%0d mode_err", i), int'(q0_e), int'(VECS[i].eerr));
            check($sformatf("R9 vec%0d mult_b", i), int'(q0_b), VECS[i].b);
        end

        // R10: early A stage, depth 2 (two edges from a_in to output)
        drive(5'b00001, 7, 0, 0);
        repeat (4) @(negedge clk);
        a = 16'sd9;
        repeat (2) @(negedge clk);
        check("R10 early stage after 2 edges", int'(q0_a), 9);
        // R10: late A stage needs three edges
        drive(5'b00000, 11, 0, 0);
        repeat (2) @(negedge clk);
        check("R10 late stage after 2 edges", int'(q0_a), 9);
        @(negedge clk);
        check("R10 late stage after 3 edges", int'(q0_a), 11);

        // R12: B stages
        drive(5'b10000, 0, 0, 3);
        repeat (4) @(negedge clk);
        b = 12'd4;
        repeat (2) @(negedge clk);
        check("R12 early B after 2 edges", int'(q0_b), 4);
        drive(5'b00000, 0, 0, 5);
        repeat (2) @(negedge clk);
        check("R12 late B after 2 edges", int'(q0_b), 4);
        @(negedge clk);
        check("R12 late B after 3 edges", int'(q0_b), 5);

        // R10 depth 0 on u1: one edge from a_in to output
        drive(5'b00000, 21, 0, 0);
        repeat (2) @(negedge clk);
        a = 16'sd23;
        @(negedge clk);
        check("R10 depth0 pass-through", int'(q1_a), 23);

        // R6: D absent on u1
        drive(5'b00001, 40, 500, 0);
        repeat (2) @(negedge clk);
        check("R6 code 0001 legal value", int'(q1_a), 40);
        check("R6 code 0001 no err", int'(q1_e), 0);
        drive(5'b00100, 40, 500, 0);
        repeat (2) @(negedge clk);
        check("R6 code 0100 err", int'(q1_e), 1);
        check("R8 code 0100 zero", int'(q1_a), 0);
        drive(5'b01000, 40, 500, 0);
        repeat (2) @(negedge clk);
        check("R6 code 1000 err", int'(q1_e), 1);
        drive(5'b00010, 40, 500, 0);
        repeat (2) @(negedge clk);
        check("R6 code 0010 no err", int'(q1_e), 0);
        check("R3 code 0010 zero on u1", int'(q1_a), 0);

        // R2: clock enable low holds outputs
        drive(5'b10101, 300, 200, 9);
        repeat (4) @(negedge clk);
        check("R2 pre-hold mult_a", int'(q0_a), 500);
        ce = 1'b0;
        drive(5'b00011, -5, -6, 1);
        repeat (4) @(negedge clk);
        check("R2 hold mult_a", int'(q0_a), 500);
        check("R2 hold mult_b", int'(q0_b), 9);
        check("R2 hold mode_err", int'(q0_e), 0);
        ce = 1'b1;

        // R1: reset mid-run clears registers and pipelines
        drive(5'b10001, 77, 0, 8);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run mult_a", int'(q0_a), 0);
        check("R1 mid-run mult_b", int'(q0_b), 0);
        rst = 1'b0;
        drive(5'b00000, 0, 0, 0);
        @(negedge clk);
        check("R1 late A stage cleared", int'(q0_a), 0);

        done = 1'b1;
        finish_run();
    end
endmodule